// File: doc/BRIEF.md
# Block Address Translation Unit

This unit turns a 32-bit effective address into a physical address through a small set of block mapping registers. There are two banks of mappings: the instruction bank serves instruction fetches, and the data bank serves loads, stores and probes. Each mapping is a pair of 32-bit words. The upper word holds the effective block base, a block length mask and two valid bits, one for supervisor state and one for user state. The lower word holds the physical block base.

The lookup is purely combinational. It uses the valid bit that matches the current privilege. It tests the mappings from the lowest index upward and takes the first one that is valid and matches. Pairs 0 to 3 form the primary group. Pairs 4 to 7 form an extended group, which is consulted only when the extended enable is high and the whole primary group has missed. When nothing matches, the unit reports a miss with a zero address, so that the surrounding logic can fall back to page translation.

The mapping words are loaded through a simple write port. Each word is addressed by a 5-bit register select and captured on the clock edge.

Top module: `blk_xlate_unit`

## Requirements
- R1: A synchronous active-low reset clears every mapping word to zero. After reset every lookup misses, in both banks and in both privilege states.
- R2: The mapping words are written on a rising clock edge when `cfg_we` is 1. The select is decoded as follows: bit 4 picks the bank (1 = instruction, 0 = data), bits 3:1 give the pair index 0..7, and bit 0 picks the word (0 = upper, 1 = lower).
- R3: The upper word is laid out as follows: effective base in bits 31:17, block length BL in bits 12:2, supervisor valid in bit 1, user valid in bit 0. With L = BL << 17, a pair matches when `((ea ^ upper) & ~L & 32'hFFFE0000) == 0`. Bits 31:28 are therefore always compared, and bits 27:17 are compared only where BL holds a 0.
- R4: When `user_mode` is 1, a pair needs upper bit 0 set to take part. When `user_mode` is 0, it needs upper bit 1 set.
- R5: On a hit, `pa = (ea & L) | (lower & 32'hFFFE0000) | (ea & 32'h0001FFFF)`.
- R6: When several pairs match, the valid matching pair with the lowest index wins, and `hit_idx` reports that index.
- R7: Pairs 4..7 take part only when `ext_en` is 1. They can win only when none of pairs 0..3 is a valid match.
- R8: On a miss, `hit` = 0, `miss` = 1 and `pa` = 0.
- R9: When `fetch` is 1, the lookup uses the instruction bank. Otherwise it uses the data bank.
- R10: Upper bits 16:13 and lower bits 16:0 are stored but have no effect on matching or on `pa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mapping word write enable |
| cfg_sel | input | 5 | Mapping word select: {bank, pair[2:0], lower} |
| cfg_wdata | input | 32 | Mapping word write data |
| ea | input | 32 | Effective address to translate |
| fetch | input | 1 | 1 = instruction fetch (instruction bank), 0 = data access |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| ext_en | input | 1 | Enables the extended group, pairs 4..7 |
| pa | output | 32 | Physical address, zero on a miss |
| hit | output | 1 | A valid pair matched |
| miss | output | 1 | No valid pair matched |
| hit_idx | output | 3 | Index of the winning pair |

## Verification
The bench builds the unit with its default parameters: four pairs per group, two groups and two banks. At that size the register file has only 32 words, so the bench rewrites every word of both banks for each of sixty configurations. The block lengths in each configuration include the empty mask, the full mask and random partial masks. Effective addresses are derived from the programmed bases, with random bits placed under the masks. Each address is then applied under all eight combinations of bank, privilege and extended enable. Because the effective bases are drawn from the same few regions, overlapping pairs, privilege-only hits and extended-group fallbacks all occur often. Directed cases cover reset, a single mask boundary bit and the ignored field bits.

// File: rtl/blk_xlate_pkg.sv
// Package: shared constants for the block address translation unit.
// Assumes 32-bit addresses with block granularity at bit 17.
package blk_xlate_pkg;
    localparam int unsigned AW      = 32;
    localparam int unsigned BLK_LSB = 17;
    localparam int unsigned LEN_W   = 11;
    localparam logic [AW-1:0] BASE_MASK = 32'hFFFE_0000;
    localparam logic [AW-1:0] OFS_MASK  = 32'h0001_FFFF;

    // Expand the length field of an upper word into the address-aligned mask L.
    function automatic logic [AW-1:0] len_mask(input logic [AW-1:0] upr);
        len_mask = {{(AW-LEN_W-BLK_LSB){1'b0}}, upr[12:2], {BLK_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/blk_xlate_regs.sv
// Module: storage for the mapping words of both banks.
// Assumes the select layout {bank, pair index, lower}. All words reset to zero.
module blk_xlate_regs #(
    parameter int unsigned NPAIRS = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned SEL_W  = IDX_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     sel,
    input  logic [31:0]          wdata,
    input  logic                 bank_i,
    output logic [NPAIRS-1:0][31:0] upr,
    output logic [NPAIRS-1:0][31:0] lwr
);
    logic [NPAIRS-1:0][31:0] d_upr, d_lwr, i_upr, i_lwr;

    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        logic hit_sel;
        assign hit_sel = we && (sel[IDX_W:1] == IDX_W'(p));

        // Capture writes aimed at this pair in either bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_upr[p] <= '0;
                d_lwr[p] <= '0;
                i_upr[p] <= '0;
                i_lwr[p] <= '0;
            end else if (hit_sel) begin
                case ({sel[SEL_W-1], sel[0]})
                    2'b00:   d_upr[p] <= wdata;
                    2'b01:   d_lwr[p] <= wdata;
                    2'b10:   i_upr[p] <= wdata;
                    default: i_lwr[p] <= wdata;
                endcase
            end
        end
    end

    // Present the bank chosen by the access type.
    always_comb begin
        upr = bank_i ? i_upr : d_upr;
        lwr = bank_i ? i_lwr : d_lwr;
    end
endmodule

// File: rtl/blk_xlate_pair.sv
// Module: match and address formation for one mapping pair.
// Assumes the upper word layout {base[31:17], unused[16:13], len[12:2], sv, uv}.
module blk_xlate_pair
    import blk_xlate_pkg::*;
(
    input  logic [AW-1:0] ea,
    input  logic [AW-1:0] upr,
    input  logic [AW-1:0] lwr,
    input  logic          user_mode,
    output logic          hit,
    output logic [AW-1:0] pa
);
    logic [AW-1:0] lmask;
    logic          vld;
    logic          match;

    // Compare the unmasked base bits and form the translated address.
    always_comb begin
        lmask = len_mask(upr);
        vld   = user_mode ? upr[0] : upr[1];
        match = (((ea ^ upr) & ~lmask & BASE_MASK) == '0);
        hit   = vld && match;
        pa    = (ea & lmask) | (lwr & BASE_MASK) | (ea & OFS_MASK);
    end
endmodule

// File: rtl/blk_xlate_prio.sv
// Module: first-match selection over the primary and extended groups.
// Assumes group 0 is always searched and later groups only with ext_en.
module blk_xlate_prio #(
    parameter int unsigned GRP_PAIRS = 4,
    parameter int unsigned GROUPS    = 2,
    parameter int unsigned NPAIRS    = GRP_PAIRS * GROUPS,
    parameter int unsigned IDX_W     = $clog2(NPAIRS)
) (
    input  logic [NPAIRS-1:0]       hits,
    input  logic [NPAIRS-1:0][31:0] pas,
    input  logic                    ext_en,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx,
    output logic [31:0]             pa
);
    logic [NPAIRS-1:0] eff;

    // Gate the extended groups with the enable.
    always_comb begin
        for (int i = 0; i < NPAIRS; i++)
            eff[i] = hits[i] && ((i < GRP_PAIRS) || ext_en);
    end

    // Pick the lowest-index effective hit.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        pa  = '0;
        for (int i = NPAIRS - 1; i >= 0; i--) begin
            if (eff[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
                pa  = pas[i];
            end
        end
    end
endmodule

// File: rtl/blk_xlate_unit.sv
// Module: top of the block address translation unit.
// Combinational lookup over registered mapping words; a miss returns zero.
module blk_xlate_unit #(
    parameter int unsigned GRP_PAIRS = 4,
    parameter int unsigned GROUPS    = 2,
    localparam int unsigned NPAIRS   = GRP_PAIRS * GROUPS,
    localparam int unsigned IDX_W    = $clog2(NPAIRS),
    localparam int unsigned SEL_W    = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic [31:0]      ea,
    input  logic             fetch,
    input  logic             user_mode,
    input  logic             ext_en,
    output logic [31:0]      pa,
    output logic             hit,
    output logic             miss,
    output logic [IDX_W-1:0] hit_idx
);
    logic [NPAIRS-1:0][31:0] upr, lwr, pas;
    logic [NPAIRS-1:0]       hits;
    logic [31:0]             sel_pa;

    blk_xlate_regs #(.NPAIRS(NPAIRS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .bank_i(fetch), .upr(upr), .lwr(lwr)
    );

    for (genvar p = 0; p < NPAIRS; p++) begin : g_match
        blk_xlate_pair u_pair (
            .ea(ea), .upr(upr[p]), .lwr(lwr[p]), .user_mode(user_mode),
            .hit(hits[p]), .pa(pas[p])
        );
    end

    blk_xlate_prio #(.GRP_PAIRS(GRP_PAIRS), .GROUPS(GROUPS)) u_prio (
        .hits(hits), .pas(pas), .ext_en(ext_en),
        .hit(hit), .idx(hit_idx), .pa(sel_pa)
    );

    // Drive the outputs; the address is already zero on a miss.
    always_comb begin
        pa   = sel_pa;
        miss = !hit;
    end
endmodule

// File: rtl/blk_xlate_chk.sv
// Module: assertion checker for blk_xlate_unit, attached by bind.
module blk_xlate_chk #(
    parameter int unsigned GRP_PAIRS = 4,
    parameter int unsigned IDX_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      ea,
    input logic             ext_en,
    input logic [31:0]      pa,
    input logic             hit,
    input logic             miss,
    input logic [IDX_W-1:0] hit_idx
);
    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (pa == 32'h0 && !hit));

    // R5
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa[16:0] == ea[16:0]));

    // R7
    ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (hit_idx >= IDX_W'(GRP_PAIRS))) |-> ext_en);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> miss);
endmodule

bind blk_xlate_unit blk_xlate_chk #(.GRP_PAIRS(GRP_PAIRS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ea(ea), .ext_en(ext_en),
    .pa(pa), .hit(hit), .miss(miss), .hit_idx(hit_idx)
);

// File: tb/tb_blk_xlate_unit.sv
module tb_blk_xlate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] ea = '0;
    logic        fetch = 1'b0, user_mode = 1'b0, ext_en = 1'b0;
    logic [31:0] pa;
    logic        hit, miss;
    logic [2:0]  hit_idx;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5679;
    logic [31:0] mu [2][8];
    logic [31:0] ml [2][8];

    always #10 clk = ~clk;  // 50 MHz

    blk_xlate_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ea(ea), .fetch(fetch), .user_mode(user_mode),
        .ext_en(ext_en), .pa(pa), .hit(hit), .miss(miss), .hit_idx(hit_idx)
    );

    function automatic logic [31:0] rnd();
        logic [31:0] s = seed;
        s ^= s << 13;
        s ^= s >> 17;
        s ^= s << 5;
        seed = s;
        return s;
    endfunction

    task automatic wr(input logic [4:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        if (sel[0]) ml[sel[4]][sel[3:1]] = data;
        else        mu[sel[4]][sel[3:1]] = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input logic f, input logic u, input logic x);
        @(negedge clk);
        ea = a; fetch = f; user_mode = u; ext_en = x;
        #5;
    endtask

    // Compare against explicit expected values.
    task automatic expect_out(input string req, input logic eh, input logic [31:0] epa,
                              input logic [2:0] eidx);
        vectors++;
        if (hit !== eh || miss !== !eh || pa !== epa || (eh && hit_idx !== eidx)) begin
            fails++;
            $display("FAIL %s ea=%h: hit=%b miss=%b pa=%h idx=%0d expected hit=%b pa=%h idx=%0d",
                     req, ea, hit, miss, pa, hit_idx, eh, epa, eidx);
        end
    endtask

    // Expected result computed from the requirements over the mirrored words.
    task automatic model(input logic [31:0] a, input logic f, input logic u, input logic x,
                         output logic h, output logic [31:0] p, output logic [2:0] idx);
        h = 1'b0; p = '0; idx = '0;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] up = mu[f][i];
            logic [31:0] lm = {4'b0, up[12:2], 17'b0};
            logic v = u ? up[0] : up[1];
            if (!h && (i < 4 || x) && v && (((a ^ up) & ~lm & 32'hFFFE_0000) == 0)) begin
                h = 1'b1;
                idx = 3'(i);
                p = (a & lm) | (ml[f][i] & 32'hFFFE_0000) | (a & 32'h0001_FFFF);
            end
        end
    endtask

    task automatic sweep_check();
        logic eh; logic [31:0] epa; logic [2:0] eidx;
        string req;
        model(ea, fetch, user_mode, ext_en, eh, epa, eidx);
        vectors++;
        if (hit !== eh || miss !== !eh || pa !== epa || (eh && hit_idx !== eidx)) begin
            fails++;
            if (hit !== eh)                 req = "R3";
            else if (miss !== !eh)          req = "R8";
            else if (eh && hit_idx !== eidx) req = "R6";
            else                            req = "R5";
            $display("FAIL %s ea=%h f=%b u=%b x=%b: hit=%b pa=%h idx=%0d expected hit=%b pa=%h idx=%0d",
                     req, ea, fetch, user_mode, ext_en, hit, pa, hit_idx, eh, epa, eidx);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int p = 0; p < 8; p++) begin mu[b][p] = '0; ml[b][p] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R8: everything misses after reset
        for (int c = 0; c < 8; c++) begin
            look(32'h8001_2345, c[0], c[1], c[2]);
            expect_out("R1", 1'b0, 32'h0, 3'd0);
        end

        // R2 / R5: data pair 0, supervisor only, BL=0
        wr(5'd0, 32'h8000_0002);
        wr(5'd1, 32'h0012_0000);
        look(32'h8001_2345, 1'b0, 1'b0, 1'b0);
        expect_out("R2", 1'b1, 32'h0013_2345, 3'd0);
        // R4: user state uses bit 0, which is clear
        look(32'h8001_2345, 1'b0, 1'b1, 1'b0);
        expect_out("R4", 1'b0, 32'h0, 3'd0);
        // R9: instruction bank is still empty
        look(32'h8001_2345, 1'b1, 1'b0, 1'b0);
        expect_out("R9", 1'b0, 32'h0, 3'd0);

        // R3 / R5: pair 1 with BL=0x7F masks bits 23:17
        wr(5'd2, 32'h9000_0000 | (32'h7F << 2) | 32'h3);
        wr(5'd3, 32'h3000_0000);
        look(32'h90AB_CDEF, 1'b0, 1'b1, 1'b0);
        expect_out("R5", 1'b1, 32'h30AB_CDEF, 3'd1);
        look(32'h910B_CDEF, 1'b0, 1'b0, 1'b0);
        expect_out("R3", 1'b0, 32'h0, 3'd0);

        // R6: pair 2 also matches, pair 1 wins
        wr(5'd4, 32'h9000_0003);
        wr(5'd5, 32'h5000_0000);
        look(32'h9001_0000, 1'b0, 1'b0, 1'b0);
        expect_out("R6", 1'b1, 32'h3001_0000, 3'd1);

        // R7: extended pair 5 only with ext_en
        wr(5'd10, 32'hA000_0002);
        wr(5'd11, 32'h6000_0000);
        look(32'hA000_0010, 1'b0, 1'b0, 1'b0);
        expect_out("R7", 1'b0, 32'h0, 3'd0);
        look(32'hA000_0010, 1'b0, 1'b0, 1'b1);
        expect_out("R7", 1'b1, 32'h6000_0010, 3'd5);
        wr(5'd8, 32'h8000_0002);
        wr(5'd9, 32'h7000_0000);
        look(32'h8001_2345, 1'b0, 1'b0, 1'b1);
        expect_out("R7", 1'b1, 32'h0013_2345, 3'd0);

        // R10: ignored field bits change nothing
        wr(5'd0, 32'h8001_E002);
        wr(5'd1, 32'h0013_FFFF);
        look(32'h8001_2345, 1'b0, 1'b0, 1'b0);
        expect_out("R10", 1'b1, 32'h0013_2345, 3'd0);

        // R9: instruction bank pair 0
        wr(5'd16, 32'h8000_0002);
        wr(5'd17, 32'h4000_0000);
        look(32'h8001_2345, 1'b1, 1'b0, 1'b0);
        expect_out("R9", 1'b1, 32'h4001_2345, 3'd0);
        look(32'h8001_2345, 1'b0, 1'b0, 1'b0);
        expect_out("R9", 1'b1, 32'h0013_2345, 3'd0);

        // Sweep: R3 R4 R5 R6 R7 R8 R9 against the arithmetic model
        for (int cfg = 0; cfg < 60; cfg++) begin
            for (int b = 0; b < 2; b++)
                for (int p = 0; p < 8; p++) begin
                    logic [31:0] r = rnd();
                    logic [31:0] r2 = rnd();
                    logic [10:0] bl;
                    logic [3:0] top;
                    case (r[1:0])
                        2'd0: bl = 11'h000;
                        2'd1: bl = 11'h7FF;
                        2'd2: bl = 11'h00F;
                        default: bl = r2[10:0];
                    endcase
                    case (r[5:4])
                        2'd0: top = 4'h8;
                        2'd1: top = 4'h9;
                        2'd2: top = 4'hA;
                        default: top = 4'hC;
                    endcase
                    wr({b[0], p[2:0], 1'b0}, {top, r2[27:17], r2[16:13], bl, r[3:2]});
                    wr({b[0], p[2:0], 1'b1}, rnd());
                end
            for (int e = 0; e < 48; e++) begin
                logic [31:0] r = rnd();
                logic [31:0] up = mu[r[0]][r[3:1]];
                logic [31:0] lm = {4'b0, up[12:2], 17'b0};
                logic [31:0] a = ((up & 32'hFFFE_0000) ^ (rnd() & lm)) | (rnd() & 32'h0001_FFFF);
                if (r[6:4] == 3'd0) a = rnd();
                for (int c = 0; c < 8; c++) begin
                    look(a, c[0], c[1], c[2]);
                    sweep_check();
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule